// File: doc/BRIEF.md
# Packed SIMD Lane Adder/Subtractor

This block adds or subtracts two 64-bit operands as a set of independent integer lanes. A lane-size select chooses eight byte lanes, four halfword lanes or two word lanes. Every lane wraps modulo its own width, and no carry or borrow crosses into the next lane. Byte and halfword lanes share one full-width adder and one full-width subtractor. A mask of lane sign bits keeps each carry inside its lane, and an XOR step restores the sign bits afterwards. Word lanes go through two separate 32-bit units.

An immediate mode serves byte and halfword adds. It takes an 8-bit signed constant, sign-extends it to the lane width and copies it into every lane in place of the second operand. Any other use of the immediate mode is reported on an unsupported flag. The same flag covers the reserved lane-size code.

A build parameter selects where the result leaves the block. It can leave through a one-cycle output register with a valid handshake, or it can bypass the register as a purely combinational path. The block sits in an execution pipeline.

Top module: `simd_lane_arith`

## Requirements
- R1: With lane_sel = 2'b00 and op_sub = 0, each of the eight byte lanes of result equals (opa byte + opb byte) mod 256, with no carry into the next byte.
- R2: With lane_sel = 2'b00 and op_sub = 1, each byte lane of result equals (opa byte - opb byte) mod 256, with no borrow from the next byte.
- R3: With lane_sel = 2'b01, each of the four 16-bit lanes of result equals the sum (op_sub = 0) or the difference (op_sub = 1) of the matching opa and opb halfwords, mod 65536.
- R4: With lane_sel = 2'b10, result bits 31:0 and 63:32 are each the 32-bit wrapped sum (op_sub = 0) or difference (op_sub = 1) of the matching operand halves.
- R5: With use_imm = 1, lane_sel = 2'b00 and op_sub = 0, every byte lane is opa byte + imm (mod 256), and opb has no effect on result.
- R6: With use_imm = 1, lane_sel = 2'b01 and op_sub = 0, imm is sign-extended from bit 7 to 16 bits and added to every halfword lane (mod 65536), and opb has no effect on result.
- R7: The unsupported output is 1 and result is all zeros when lane_sel = 2'b11, or when use_imm = 1 together with op_sub = 1 or lane_sel = 2'b10. Otherwise unsupported is 0.
- R8: With REG_OUT = 1, result and unsupported appear one clock after a cycle with in_valid high, and out_valid equals in_valid delayed by one clock. A synchronous active-low reset clears out_valid, result and unsupported to 0.
- R9: With REG_OUT = 0, result and unsupported follow the inputs combinationally, and out_valid equals in_valid in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands valid this cycle |
| opa | input | 64 | First operand |
| opb | input | 64 | Second operand (ignored in immediate mode) |
| imm | input | 8 | Signed immediate for the broadcast modes |
| lane_sel | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| op_sub | input | 1 | 0 add, 1 subtract |
| use_imm | input | 1 | 1 replaces opb with the broadcast immediate |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Packed lane result |
| unsupported | output | 1 | Operation combination not available |

## Verification
A wrong mask bit or a missing XOR correction shows up as one corrupted lane, usually the lane above a lane-boundary carry such as 0x7F+0x01 or 0x00-0x01. With the register present it appears on result one clock after the stimulus. A wrong sign extension of the immediate corrupts the upper byte of every halfword lane whenever imm is negative. A broken unsupported decode shows a nonzero result or a wrong flag in the same cycle as the other results. A fault in the valid register shows out_valid that is out of step with in_valid by one cycle, starting from the first cycle after reset.

// File: rtl/simd_lane_pkg.sv
// Package: shared lane-size encoding for the packed lane arithmetic unit.
// Assumes the datapath width is a multiple of the widest lane.
package simd_lane_pkg;

    // Lane-size select encoding seen at the top ports.
    typedef enum logic [1:0] {
        LANE_BYTE = 2'b00,
        LANE_HALF = 2'b01,
        LANE_WORD = 2'b10,
        LANE_RSV  = 2'b11
    } lane_e;

    localparam int BYTE_W = 8;
    localparam int HALF_W = 16;
    localparam int WORD_W = 32;

endpackage

// File: rtl/simd_imm_bcast.sv
// Module: immediate broadcast.
// Sign-extends a small signed immediate to the byte or halfword lane width
// and copies it into every lane of a DATA_W vector.
// Assumes DATA_W is a multiple of 16 and IMM_W <= 8.
module simd_imm_bcast #(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 8
) (
    input  logic [IMM_W-1:0]  imm,
    input  logic              half_mode,
    output logic [DATA_W-1:0] bcast
);
    import simd_lane_pkg::*;

    localparam int N_BYTE = DATA_W / BYTE_W;
    localparam int N_HALF = DATA_W / HALF_W;

    logic [BYTE_W-1:0] imm_b;
    logic [HALF_W-1:0] imm_h;
    logic [DATA_W-1:0] rep_b;
    logic [DATA_W-1:0] rep_h;

    // Sign-extend the immediate to both lane widths.
    always_comb begin
        imm_b = {{(BYTE_W-IMM_W){imm[IMM_W-1]}}, imm};
        imm_h = {{(HALF_W-IMM_W){imm[IMM_W-1]}}, imm};
    end

    for (genvar gb = 0; gb < N_BYTE; gb++) begin : g_rep_b
        assign rep_b[gb*BYTE_W +: BYTE_W] = imm_b;
    end

    for (genvar gh = 0; gh < N_HALF; gh++) begin : g_rep_h
        assign rep_h[gh*HALF_W +: HALF_W] = imm_h;
    end

    // Pick the replica that matches the lane size.
    always_comb begin
        bcast = half_mode ? rep_h : rep_b;
    end
endmodule

// File: rtl/simd_masked_addsub.sv
// Module: masked full-width lane add and subtract for byte or halfword lanes.
// A mask holding only each lane's top bit is cleared from the operands so that
// no carry or borrow passes a lane edge; the top bits are then fixed by XOR.
// Assumes DATA_W is a multiple of 16. clk and rst_n feed only the assertions.
module simd_masked_addsub #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    input  logic              half_mode,
    output logic [DATA_W-1:0] res
);
    import simd_lane_pkg::*;

    logic [DATA_W-1:0] sign_m;
    logic [DATA_W-1:0] sum_raw;
    logic [DATA_W-1:0] dif_raw;
    logic [DATA_W-1:0] add_res;
    logic [DATA_W-1:0] sub_res;

    // One mask bit per datapath bit: set only at a lane's top bit.
    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_mask
        assign sign_m[gi] = half_mode ? ((gi % HALF_W) == HALF_W-1)
                                      : ((gi % BYTE_W) == BYTE_W-1);
    end

    // Masked add: lower bits summed, top bits rebuilt from operand parity.
    always_comb begin
        sum_raw = (a & ~sign_m) + (b & ~sign_m);
        add_res = sum_raw ^ ((a ^ b) & sign_m);
    end

    // Masked subtract: top bit forced high to absorb the borrow, then fixed.
    always_comb begin
        dif_raw = (a | sign_m) - (b & ~sign_m);
        sub_res = dif_raw ^ (~(a ^ b) & sign_m);
    end

    // Choose the operation result.
    always_comb begin
        res = sub ? sub_res : add_res;
    end

    // R1
    top_byte_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!half_mode && !sub) |->
            res[DATA_W-1 -: BYTE_W] == BYTE_W'(a[DATA_W-1 -: BYTE_W] + b[DATA_W-1 -: BYTE_W]));

    // R2
    top_byte_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!half_mode && sub) |->
            res[DATA_W-1 -: BYTE_W] == BYTE_W'(a[DATA_W-1 -: BYTE_W] - b[DATA_W-1 -: BYTE_W]));

    // R3
    top_half_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (half_mode && !sub) |->
            res[DATA_W-1 -: HALF_W] == HALF_W'(a[DATA_W-1 -: HALF_W] + b[DATA_W-1 -: HALF_W]));
endmodule

// File: rtl/simd_word_addsub.sv
// Module: word-lane add and subtract.
// Splits the operands into WORD_W slices and gives each slice its own
// adder/subtractor, then joins the slices in their original positions.
// Assumes DATA_W is a multiple of WORD_W. clk and rst_n feed only the assertions.
module simd_word_addsub #(
    parameter int DATA_W = 64,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    output logic [DATA_W-1:0] res
);
    localparam int N_WORD = DATA_W / WORD_W;

    for (genvar gw = 0; gw < N_WORD; gw++) begin : g_word
        logic [WORD_W-1:0] wa;
        logic [WORD_W-1:0] wb;
        logic [WORD_W-1:0] wr;

        // Per-slice add or subtract that wraps at the slice width.
        always_comb begin
            wa = a[gw*WORD_W +: WORD_W];
            wb = b[gw*WORD_W +: WORD_W];
            wr = sub ? (wa - wb) : (wa + wb);
        end

        assign res[gw*WORD_W +: WORD_W] = wr;
    end

    // R4
    low_word_inverse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sub |-> WORD_W'(res[WORD_W-1:0] - b[WORD_W-1:0]) == a[WORD_W-1:0]);
endmodule

// File: rtl/simd_out_stage.sv
// Module: optional output stage.
// REG_OUT = 1 registers data and flag when in_valid is high and delays the
// valid by one clock; REG_OUT = 0 passes everything straight through.
// Reset is synchronous and active low.
module simd_out_stage #(
    parameter int DATA_W  = 64,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] d,
    input  logic              d_flag,
    output logic              out_valid,
    output logic [DATA_W-1:0] q,
    output logic              q_flag
);
    if (REG_OUT) begin : g_reg
        logic              vld_r;
        logic [DATA_W-1:0] q_r;
        logic              flag_r;

        // Capture the result on valid input; clear everything on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_r  <= 1'b0;
                q_r    <= '0;
                flag_r <= 1'b0;
            end else begin
                vld_r <= in_valid;
                if (in_valid) begin
                    q_r    <= d;
                    flag_r <= d_flag;
                end
            end
        end

        assign out_valid = vld_r;
        assign q         = q_r;
        assign q_flag    = flag_r;

        // R8
        valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);

        // R8
        valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);
    end else begin : g_bypass
        assign out_valid = in_valid;
        assign q         = d;
        assign q_flag    = d_flag;
    end
endmodule

// File: rtl/simd_lane_arith.sv
// Module: packed SIMD lane adder/subtractor (top).
// Decodes lane size and mode, routes byte/halfword work to the masked
// full-width unit and word work to the split unit, substitutes the broadcast
// immediate for opb in immediate mode, and flags unsupported combinations.
// Assumes DATA_W is a multiple of 32.
module simd_lane_arith #(
    parameter int DATA_W  = 64,
    parameter int IMM_W   = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [IMM_W-1:0]  imm,
    input  logic [1:0]        lane_sel,
    input  logic              op_sub,
    input  logic              use_imm,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              unsupported
);
    import simd_lane_pkg::*;

    lane_e             lane;
    logic              half_mode;
    logic              bad_combo;
    logic [DATA_W-1:0] bcast;
    logic [DATA_W-1:0] opb_eff;
    logic [DATA_W-1:0] mask_res;
    logic [DATA_W-1:0] word_res;
    logic [DATA_W-1:0] res_c;

    // Decode the lane size and flag combinations the unit does not offer.
    always_comb begin
        lane      = lane_e'(lane_sel);
        half_mode = (lane == LANE_HALF);
        bad_combo = (lane == LANE_RSV) ||
                    (use_imm && (op_sub || lane == LANE_WORD));
    end

    simd_imm_bcast #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_bcast (
        .imm       (imm),
        .half_mode (half_mode),
        .bcast     (bcast)
    );

    // Second operand: register operand or broadcast immediate.
    always_comb begin
        opb_eff = use_imm ? bcast : opb;
    end

    simd_masked_addsub #(.DATA_W(DATA_W)) u_masked (
        .clk       (clk),
        .rst_n     (rst_n),
        .a         (opa),
        .b         (opb_eff),
        .sub       (op_sub),
        .half_mode (half_mode),
        .res       (mask_res)
    );

    simd_word_addsub #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_word (
        .clk   (clk),
        .rst_n (rst_n),
        .a     (opa),
        .b     (opb_eff),
        .sub   (op_sub),
        .res   (word_res)
    );

    // Final result select; unsupported combinations give zero.
    always_comb begin
        if (bad_combo)
            res_c = '0;
        else if (lane == LANE_WORD)
            res_c = word_res;
        else
            res_c = mask_res;
    end

    simd_out_stage #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .d         (res_c),
        .d_flag    (bad_combo),
        .out_valid (out_valid),
        .q         (result),
        .q_flag    (unsupported)
    );
endmodule

// File: tb/simd_lane_arith_tb.sv
// Bench: table-driven and random checks of the packed lane unit, with a
// registered instance (dut_i) and a combinational instance (dut_comb_i).
module simd_lane_arith_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] opa = '0;
    logic [63:0] opb = '0;
    logic [7:0]  imm = '0;
    logic [1:0]  lane_sel = '0;
    logic        op_sub = 1'b0;
    logic        use_imm = 1'b0;

    logic        out_valid, unsupported;
    logic [63:0] result;
    logic        out_valid_c, unsupported_c;
    logic [63:0] result_c;

    int n_total = 0;
    int n_bad   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    simd_lane_arith #(.REG_OUT(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opa(opa), .opb(opb),
        .imm(imm), .lane_sel(lane_sel), .op_sub(op_sub), .use_imm(use_imm),
        .out_valid(out_valid), .result(result), .unsupported(unsupported)
    );

    simd_lane_arith #(.REG_OUT(1'b0)) dut_comb_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opa(opa), .opb(opb),
        .imm(imm), .lane_sel(lane_sel), .op_sub(op_sub), .use_imm(use_imm),
        .out_valid(out_valid_c), .result(result_c), .unsupported(unsupported_c)
    );

    typedef struct packed {
        logic [1:0]  lane;
        logic        sub;
        logic        uimm;
        logic [7:0]  imm;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] exp;
        logic        exp_uns;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VT [NV] = '{
        // R1 byte add across lane carries
        '{2'b00, 1'b0, 1'b0, 8'h00, 64'h7FFF_0080_0102_0304, 64'h0101_0180_FF02_0304, 64'h8000_0100_0004_0608, 1'b0},
        // R2 byte subtract across lane borrows
        '{2'b00, 1'b1, 1'b0, 8'h00, 64'h0000_0080_7F10_FF05, 64'h0180_0001_FF01_FF06, 64'hFF80_007F_800F_00FF, 1'b0},
        // R3 halfword add
        '{2'b01, 1'b0, 1'b0, 8'h00, 64'h7FFF_FFFF_1234_8000, 64'h0001_0001_1111_8000, 64'h8000_0000_2345_0000, 1'b0},
        // R3 halfword subtract
        '{2'b01, 1'b1, 1'b0, 8'h00, 64'h8000_0000_1234_0001, 64'h0001_0001_0234_0002, 64'h7FFF_FFFF_1000_FFFF, 1'b0},
        // R4 word add
        '{2'b10, 1'b0, 1'b0, 8'h00, 64'hFFFF_FFFF_7FFF_FFFF, 64'h0000_0001_0000_0001, 64'h0000_0000_8000_0000, 1'b0},
        // R4 word subtract
        '{2'b10, 1'b1, 1'b0, 8'h00, 64'h0000_0000_0000_0005, 64'h0000_0001_0000_0006, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0},
        // R5 byte immediate +1, opb nonzero
        '{2'b00, 1'b0, 1'b1, 8'h01, 64'hFF7F_0001_0203_FEFF, 64'h5555_AAAA_1234_5678, 64'h0080_0102_0304_FF00, 1'b0},
        // R5 byte immediate -1
        '{2'b00, 1'b0, 1'b1, 8'hFF, 64'h0001_8000_7F10_2030, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFF00_7FFF_7E0F_1F2F, 1'b0},
        // R6 halfword immediate -2, sign-extended
        '{2'b01, 1'b0, 1'b1, 8'hFE, 64'h0000_0001_8001_1234, 64'h0F0F_0F0F_0F0F_0F0F, 64'hFFFE_FFFF_7FFF_1232, 1'b0},
        // R6 halfword immediate +127
        '{2'b01, 1'b0, 1'b1, 8'h7F, 64'hFFFF_7F81_0000_FF80, 64'h1111_2222_3333_4444, 64'h007E_8000_007F_FFFF, 1'b0},
        // R7 word immediate
        '{2'b10, 1'b0, 1'b1, 8'h05, 64'h1234_5678_9ABC_DEF0, 64'h1, 64'h0, 1'b1},
        // R7 byte immediate with subtract
        '{2'b00, 1'b1, 1'b1, 8'h05, 64'h1234_5678_9ABC_DEF0, 64'h1, 64'h0, 1'b1},
        // R7 reserved lane code
        '{2'b11, 1'b0, 1'b0, 8'h00, 64'h1234_5678_9ABC_DEF0, 64'h1, 64'h0, 1'b1},
        // R7 halfword immediate add is supported
        '{2'b01, 1'b0, 1'b1, 8'h00, 64'h1234_5678_9ABC_DEF0, 64'h1, 64'h1234_5678_9ABC_DEF0, 1'b0}
    };

    // Record one comparison; print a FAIL line on mismatch.
    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_total++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Requirement tag for a vector, from its fields.
    function automatic string req_of(input logic [1:0] l, input logic s, input logic u);
        if (l == 2'b11 || (u && (s || l == 2'b10))) return "R7";
        if (u) return (l == 2'b00) ? "R5" : "R6";
        if (l == 2'b10) return "R4";
        if (l == 2'b01) return "R3";
        return s ? "R2" : "R1";
    endfunction

    // Independent lane-by-lane reference: {unsupported, result}.
    function automatic logic [64:0] ref_model(input logic [1:0] l, input logic s,
        input logic u, input logic [7:0] im, input logic [63:0] a, input logic [63:0] b);
        int w;
        logic [63:0] lm, x, y, r, acc;
        if (l == 2'b11 || (u && (s || l == 2'b10))) return {1'b1, 64'h0};
        w  = (l == 2'b00) ? 8 : (l == 2'b01) ? 16 : 32;
        lm = (64'h1 << w) - 64'h1;
        acc = '0;
        for (int k = 0; k < 64 / w; k++) begin
            x = (a >> (k * w)) & lm;
            y = u ? ({{56{im[7]}}, im} & lm) : ((b >> (k * w)) & lm);
            r = (s ? (x - y) : (x + y)) & lm;
            acc = acc | (r << (k * w));
        end
        return {1'b0, acc};
    endfunction

    // Apply one operation; check the bypass instance now and the registered one a clock later.
    task automatic run_op(input logic [1:0] l, input logic s, input logic u,
        input logic [7:0] im, input logic [63:0] a, input logic [63:0] b,
        input logic [63:0] exp, input logic exp_uns, input string req);
        @(negedge clk);
        lane_sel = l; op_sub = s; use_imm = u; imm = im; opa = a; opb = b;
        in_valid = 1'b1;
        #1;
        chk({req, " R9 comb result"}, result_c, exp);
        chk({req, " R9 comb flag"}, {63'h0, unsupported_c}, {63'h0, exp_uns});
        chk("R9 comb valid", {63'h0, out_valid_c}, 64'h1);
        @(negedge clk);
        chk({req, " R8 reg result"}, result, exp);
        chk({req, " R8 reg flag"}, {63'h0, unsupported}, {63'h0, exp_uns});
        chk("R8 reg valid", {63'h0, out_valid}, 64'h1);
    endtask

    initial begin
        // Reset held with active inputs: registered outputs stay cleared (R8).
        in_valid = 1'b1; opa = 64'hFFFF_FFFF_FFFF_FFFF; opb = 64'h1;
        repeat (3) @(negedge clk);
        chk("R8 reset valid", {63'h0, out_valid}, 64'h0);
        chk("R8 reset result", result, 64'h0);
        chk("R8 reset flag", {63'h0, unsupported}, 64'h0);
        rst_n = 1'b1;
        in_valid = 1'b0;

        // Table walk.
        for (int i = 0; i < NV; i++) begin
            run_op(VT[i].lane, VT[i].sub, VT[i].uimm, VT[i].imm, VT[i].a, VT[i].b,
                   VT[i].exp, VT[i].exp_uns, req_of(VT[i].lane, VT[i].sub, VT[i].uimm));
        end

        // Valid drop: out_valid falls one clock after in_valid (R8, R9).
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        chk("R9 comb valid low", {63'h0, out_valid_c}, 64'h0);
        @(negedge clk);
        chk("R8 reg valid low", {63'h0, out_valid}, 64'h0);

        // Lane-edge corner cases through the reference model.
        begin
            logic [64:0] m;
            m = ref_model(2'b00, 1'b0, 1'b0, 8'h0, 64'h7F7F_FFFF_7F7F_FFFF, 64'h0101_0101_0101_0101);
            run_op(2'b00, 1'b0, 1'b0, 8'h0, 64'h7F7F_FFFF_7F7F_FFFF, 64'h0101_0101_0101_0101, m[63:0], m[64], "R1");
            m = ref_model(2'b00, 1'b1, 1'b0, 8'h0, 64'h0, 64'h0101_0101_0101_0101);
            run_op(2'b00, 1'b1, 1'b0, 8'h0, 64'h0, 64'h0101_0101_0101_0101, m[63:0], m[64], "R2");
            m = ref_model(2'b01, 1'b1, 1'b0, 8'h0, 64'h8000_8000_0000_8000, 64'h0001_0001_0001_0001);
            run_op(2'b01, 1'b1, 1'b0, 8'h0, 64'h8000_8000_0000_8000, 64'h0001_0001_0001_0001, m[63:0], m[64], "R3");
        end

        // Random operations checked against the reference model.
        for (int n = 0; n < 300; n++) begin
            logic [1:0]  l;
            logic        s, u;
            logic [7:0]  im;
            logic [63:0] a, b;
            logic [64:0] m;
            l  = 2'($urandom_range(0, 3));
            s  = 1'($urandom);
            u  = ($urandom_range(0, 3) == 0);
            im = 8'($urandom);
            a  = {$urandom, $urandom};
            b  = {$urandom, $urandom};
            m  = ref_model(l, s, u, im, a, b);
            run_op(l, s, u, im, a, b, m[63:0], m[64], req_of(l, s, u));
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_total++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    end
endmodule